// File: doc/BRIEF.md
# Up-Down Timer Event Blanking and Windowing Filter

This block sits beside the counter of a PWM timing unit and decides, cycle by cycle, whether a raw external event may go on to the rest of the unit. It contains its own counter, which runs either up-only (sawtooth) or up-down (center-aligned) between zero and a programmable period. Four compare values, a period value and a roll-over mode field define the points at which intervals open and close. A 4-bit filter code, read together with the count-mode bit, selects one interval.

The selected interval is used in one of two ways. A blanking interval suppresses any event that falls inside it. A windowing interval lets through only the events that fall inside it. In up-only mode the intervals start at the counter roll-over. In up-down mode they are tied to one counting phase, or to a span across both phases, so the counter direction takes part in every decision. One code uses a window signal supplied by another timing unit. An interval that lasts more than one cycle keeps its state in a single register.

Top module: `udt_event_filter`

## Requirements
- R1: With `updown_mode` low and `run` high, the counter steps up by one each cycle. In the cycle after it holds a value greater than or equal to `period`, it reads zero.
- R2: With `updown_mode` high, the counter counts up until it holds a value of at least `period`, then counts down. After it holds zero while counting down, it counts up again. The direction flips in the cycle after the turning value. A turning value belongs to the phase in which it was reached: the top belongs to the up phase and the bottom to the down phase.
- R3: After a synchronous reset, the counter holds zero, counts up, and the interval state is clear.
- R4: In up-only mode, each of the following codes opens an interval at a roll-over event and closes it at a compare match: code 0010 blanks and closes at compare 2; code 0100 blanks and closes at compare 4; code 1101 is a window that closes at compare 2; code 1110 is a window that closes at compare 3. The opening cycle lies inside the interval and the closing cycle lies outside it. When both happen in one cycle, the close wins.
- R5: The roll-over field selects where roll-over events occur. Value 01 fires when the count is zero. Value 10 fires when the count equals `period`. Values 00 and 11 fire at both places.
- R6: In up-down mode, code 0010 blanks from a compare 1 match to a compare 2 match, and code 0100 blanks from compare 3 to compare 4. Both matches must occur in the up phase, and the interval ends as soon as the counter leaves the up phase.
- R7: In up-down mode, code 1101 is a window from compare 2 to compare 3, limited to the up phase. Code 1110 is a window from compare 2 to compare 3, limited to the down phase.
- R8: In up-only mode, code 1111 passes an event only while `ext_window` is high.
- R9: In up-down mode, code 1111 is a window that opens at a compare 2 match in the up phase and closes at a compare 3 match in the down phase, staying open across the turnaround.
- R10: Any code other than 0010, 0100, 1101, 1110 and 1111 passes `raw_evt` to `evt_out` unchanged.
- R11: `evt_out` is combinational and is raised only in a cycle where `raw_evt` is high.
- R12: While `run` is low, a change of `filt_code` or `updown_mode` from one cycle to the next clears the interval state. While `run` is low and the configuration is unchanged, the state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter advances while high |
| updown_mode | input | 1 | 0: up-only counting, 1: up-down counting |
| filt_code | input | 4 | Filter selection code |
| roll_mode | input | 2 | Roll-over event placement |
| period | input | W | Top value of the count |
| cmp1_val | input | W | Compare value 1 |
| cmp2_val | input | W | Compare value 2 |
| cmp3_val | input | W | Compare value 3 |
| cmp4_val | input | W | Compare value 4 |
| raw_evt | input | 1 | Unfiltered single-cycle event |
| ext_window | input | 1 | Window level from another timing unit |
| evt_out | output | 1 | Filtered event |

## Verification
The bench goes after the edges of each interval. It checks that the opening cycle is inside the interval and the closing cycle is outside it, and that a close landing on the same cycle as an open wins. A design off by one at either edge would let through, or swallow, exactly the event at a compare value. Compare values placed on zero and on the period test phase membership at the turnarounds. A design that took the direction from the next cycle would misplace windows at the top and bottom of the count.

The roll-over placement is swept in every mode. A design that ignored the field would blank the event at the period value when it should not. The bench also stops the counter while a spanning window is open, then edits the code and restores it. A design that failed to clear the held state would still pass events after the edit, and one that cleared it without an edit would drop them.

// File: rtl/evt_filt_pkg.sv
`timescale 1ns/1ps
package evt_filt_pkg;

    localparam int N_CMP = 4;

    localparam logic [3:0] FC_BLANK_A = 4'b0010;
    localparam logic [3:0] FC_BLANK_B = 4'b0100;
    localparam logic [3:0] FC_WIN_A   = 4'b1101;
    localparam logic [3:0] FC_WIN_B   = 4'b1110;
    localparam logic [3:0] FC_WIN_X   = 4'b1111;

    typedef enum logic [1:0] {FK_PASS, FK_BLANK, FK_WINDOW, FK_EXTWIN} filt_kind_e;
    typedef enum logic [2:0] {EV_NONE, EV_ROLL, EV_CMP1, EV_CMP2, EV_CMP3, EV_CMP4} ev_src_e;
    typedef enum logic [1:0] {PH_ANY, PH_UP, PH_DOWN} phase_e;
    typedef enum logic [1:0] {RO_BOTH, RO_BOTTOM, RO_TOP, RO_BOTH_ALT} roll_sel_e;

    typedef struct packed {
        filt_kind_e kind;
        ev_src_e    open_src;
        phase_e     open_ph;
        ev_src_e    close_src;
        phase_e     close_ph;
        phase_e     stay_ph;
    } filt_sel_t;

    typedef struct packed {
        logic             roll;
        logic [N_CMP-1:0] cmp;
    } ev_flags_t;

    function automatic filt_sel_t decode_filter(input logic [3:0] code, input logic updown);
        filt_sel_t s;
        s.kind      = FK_PASS;
        s.open_src  = EV_NONE;
        s.open_ph   = PH_ANY;
        s.close_src = EV_NONE;
        s.close_ph  = PH_ANY;
        s.stay_ph   = PH_ANY;
        if (!updown) begin
            case (code)
                FC_BLANK_A: begin s.kind = FK_BLANK;  s.open_src = EV_ROLL; s.close_src = EV_CMP2; end
                FC_BLANK_B: begin s.kind = FK_BLANK;  s.open_src = EV_ROLL; s.close_src = EV_CMP4; end
                FC_WIN_A:   begin s.kind = FK_WINDOW; s.open_src = EV_ROLL; s.close_src = EV_CMP2; end
                FC_WIN_B:   begin s.kind = FK_WINDOW; s.open_src = EV_ROLL; s.close_src = EV_CMP3; end
                FC_WIN_X:   s.kind = FK_EXTWIN;
                default:    s.kind = FK_PASS;
            endcase
        end else begin
            case (code)
                FC_BLANK_A: begin
                    s.kind = FK_BLANK; s.open_src = EV_CMP1; s.close_src = EV_CMP2;
                    s.open_ph = PH_UP; s.close_ph = PH_UP; s.stay_ph = PH_UP;
                end
                FC_BLANK_B: begin
                    s.kind = FK_BLANK; s.open_src = EV_CMP3; s.close_src = EV_CMP4;
                    s.open_ph = PH_UP; s.close_ph = PH_UP; s.stay_ph = PH_UP;
                end
                FC_WIN_A: begin
                    s.kind = FK_WINDOW; s.open_src = EV_CMP2; s.close_src = EV_CMP3;
                    s.open_ph = PH_UP; s.close_ph = PH_UP; s.stay_ph = PH_UP;
                end
                FC_WIN_B: begin
                    s.kind = FK_WINDOW; s.open_src = EV_CMP2; s.close_src = EV_CMP3;
                    s.open_ph = PH_DOWN; s.close_ph = PH_DOWN; s.stay_ph = PH_DOWN;
                end
                FC_WIN_X: begin
                    s.kind = FK_WINDOW; s.open_src = EV_CMP2; s.close_src = EV_CMP3;
                    s.open_ph = PH_UP; s.close_ph = PH_DOWN; s.stay_ph = PH_ANY;
                end
                default: s.kind = FK_PASS;
            endcase
        end
        return s;
    endfunction

    function automatic logic phase_ok(input phase_e ph, input logic dir_up);
        case (ph)
            PH_UP:   return dir_up;
            PH_DOWN: return !dir_up;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic pick_ev(input ev_src_e src, input ev_flags_t f);
        case (src)
            EV_ROLL: return f.roll;
            EV_CMP1: return f.cmp[0];
            EV_CMP2: return f.cmp[1];
            EV_CMP3: return f.cmp[2];
            EV_CMP4: return f.cmp[3];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/udt_counter.sv
`timescale 1ns/1ps
module udt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         updown,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         dir_up
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            dir_up <= 1'b1;
        end else if (run) begin
            if (!updown) begin
                dir_up <= 1'b1;
                count  <= (count >= period) ? '0 : count + ONE;
            end else if (dir_up) begin
                if (count >= period) begin
                    dir_up <= 1'b0;
                    count  <= (count == '0) ? '0 : count - ONE;
                end else begin
                    count  <= count + ONE;
                end
            end else begin
                if (count == '0) begin
                    dir_up <= 1'b1;
                    count  <= (period == '0) ? '0 : ONE;
                end else begin
                    count  <= count - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/udt_event_gen.sv
`timescale 1ns/1ps
module udt_event_gen
    import evt_filt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]            count,
    input  logic [W-1:0]            period,
    input  logic [N_CMP-1:0][W-1:0] cmp,
    input  logic [1:0]              roll_mode,
    output ev_flags_t               flags
);

    logic [N_CMP-1:0] hit;
    logic at_bottom, at_top, roll;

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign hit[g] = (count == cmp[g]);
    end

    assign at_bottom = (count == '0);
    assign at_top    = (count == period);

    always_comb begin
        case (roll_sel_e'(roll_mode))
            RO_BOTTOM: roll = at_bottom;
            RO_TOP:    roll = at_top;
            default:   roll = at_bottom | at_top;
        endcase
        flags.roll = roll;
        flags.cmp  = hit;
    end

endmodule

// File: rtl/udt_interval.sv
`timescale 1ns/1ps
module udt_interval
    import evt_filt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       updown,
    input  logic [3:0] code,
    input  logic       dir_up,
    input  ev_flags_t  flags,
    input  logic       raw_evt,
    input  logic       ext_window,
    output logic       evt_out,
    output logic       span_held
);

    filt_sel_t  sel;
    logic       open_ev, close_ev, in_phase, active, cfg_edit;
    logic [3:0] code_q;
    logic       mode_q;

    always_comb begin
        sel      = decode_filter(code, updown);
        open_ev  = pick_ev(sel.open_src, flags)  & phase_ok(sel.open_ph, dir_up);
        close_ev = pick_ev(sel.close_src, flags) & phase_ok(sel.close_ph, dir_up);
        in_phase = phase_ok(sel.stay_ph, dir_up);
        active   = (sel.kind == FK_BLANK || sel.kind == FK_WINDOW)
                 & in_phase & ~close_ev & (open_ev | span_held);
        case (sel.kind)
            FK_BLANK:  evt_out = raw_evt & ~active;
            FK_WINDOW: evt_out = raw_evt & active;
            FK_EXTWIN: evt_out = raw_evt & ext_window;
            default:   evt_out = raw_evt;
        endcase
    end

    assign cfg_edit = !run && ((code != code_q) || (updown != mode_q));

    always_ff @(posedge clk) begin
        code_q <= code;
        mode_q <= updown;
        if (rst || cfg_edit) begin
            span_held <= 1'b0;
        end else begin
            span_held <= active;
        end
    end

endmodule

// File: rtl/udt_event_filter.sv
`timescale 1ns/1ps
module udt_event_filter
    import evt_filt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         updown_mode,
    input  logic [3:0]   filt_code,
    input  logic [1:0]   roll_mode,
    input  logic [W-1:0] period,
    input  logic [W-1:0] cmp1_val,
    input  logic [W-1:0] cmp2_val,
    input  logic [W-1:0] cmp3_val,
    input  logic [W-1:0] cmp4_val,
    input  logic         raw_evt,
    input  logic         ext_window,
    output logic         evt_out
);

    logic [W-1:0]            cnt_q;
    logic                    dir_up;
    logic                    span_held;
    ev_flags_t               flags;
    logic [N_CMP-1:0][W-1:0] cmp_bus;

    assign cmp_bus = {cmp4_val, cmp3_val, cmp2_val, cmp1_val};

    udt_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .updown (updown_mode),
        .period (period),
        .count  (cnt_q),
        .dir_up (dir_up)
    );

    udt_event_gen #(.W(W)) u_evg (
        .count     (cnt_q),
        .period    (period),
        .cmp       (cmp_bus),
        .roll_mode (roll_mode),
        .flags     (flags)
    );

    udt_interval u_intv (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .updown     (updown_mode),
        .code       (filt_code),
        .dir_up     (dir_up),
        .flags      (flags),
        .raw_evt    (raw_evt),
        .ext_window (ext_window),
        .evt_out    (evt_out),
        .span_held  (span_held)
    );

endmodule

// File: rtl/udt_event_filter_chk.sv
`timescale 1ns/1ps
module udt_event_filter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         updown_mode,
    input logic [3:0]   filt_code,
    input logic         raw_evt,
    input logic         evt_out,
    input logic [W-1:0] period,
    input logic [W-1:0] cnt,
    input logic         dir_up,
    input logic         span_held
);

    logic vld;
    logic listed;

    always_ff @(posedge clk) begin
        if (rst) vld <= 1'b0;
        else     vld <= 1'b1;
    end

    assign listed = (filt_code == 4'b0010) || (filt_code == 4'b0100) ||
                    (filt_code == 4'b1101) || (filt_code == 4'b1110) ||
                    (filt_code == 4'b1111);

    // R11
    evt_needs_raw_chk: assert property (@(posedge clk) disable iff (rst)
        evt_out |-> raw_evt);

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !listed |-> (evt_out == raw_evt));

    // R1
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !updown_mode && cnt >= period) |=> (cnt == '0));

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && run && !updown_mode && cnt < period) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R2
    top_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (run && updown_mode && dir_up && cnt >= period) |=> !dir_up);

    // R2
    bottom_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (run && updown_mode && !dir_up && cnt == '0) |=> dir_up);

    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && dir_up && !span_held));

    // R12
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !run && filt_code != $past(filt_code)) |=> !span_held);

endmodule

bind udt_event_filter udt_event_filter_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .updown_mode (updown_mode),
    .filt_code   (filt_code),
    .raw_evt     (raw_evt),
    .evt_out     (evt_out),
    .period      (period),
    .cnt         (cnt_q),
    .dir_up      (dir_up),
    .span_held   (span_held)
);

// File: tb/udt_event_filter_tb.sv
`timescale 1ns/1ps
module udt_event_filter_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         run;
    logic         updown_mode;
    logic [3:0]   filt_code;
    logic [1:0]   roll_mode;
    logic [W-1:0] period;
    logic [W-1:0] cmp1_val, cmp2_val, cmp3_val, cmp4_val;
    logic         raw_evt;
    logic         ext_window;
    logic         evt_out;

    int vectors = 0;
    int fails   = 0;

    int   m_cnt;
    logic m_up;
    logic m_held;
    logic [3:0] m_pcode;
    logic m_pmode;

    always #10 clk = ~clk;

    udt_event_filter #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .run(run), .updown_mode(updown_mode),
        .filt_code(filt_code), .roll_mode(roll_mode), .period(period),
        .cmp1_val(cmp1_val), .cmp2_val(cmp2_val), .cmp3_val(cmp3_val), .cmp4_val(cmp4_val),
        .raw_evt(raw_evt), .ext_window(ext_window), .evt_out(evt_out)
    );

    function automatic string req_tag(input logic md, input logic [3:0] c);
        if (!md) begin
            if (c == 4'b0010 || c == 4'b0100 || c == 4'b1101 || c == 4'b1110) return "R4 R5 R1 R11";
            if (c == 4'b1111) return "R8 R1 R11";
            return "R10 R1 R11";
        end
        if (c == 4'b0010 || c == 4'b0100) return "R6 R2 R11";
        if (c == 4'b1101 || c == 4'b1110) return "R7 R2 R11";
        if (c == 4'b1111) return "R9 R2 R11";
        return "R10 R2 R11";
    endfunction

    // Expected output from the requirement text, evaluated on the bench's own state.
    task automatic model_eval(output logic e_out, output logic e_act);
        int per;
        logic roll, mt1, mt2, mt3, mt4;
        logic op, cl, ph;
        int kind; // 0 pass, 1 blank, 2 window, 3 external
        per = int'(period);
        case (roll_mode)
            2'd1:    roll = (m_cnt == 0);
            2'd2:    roll = (m_cnt == per);
            default: roll = (m_cnt == 0) || (m_cnt == per);
        endcase
        mt1 = (m_cnt == int'(cmp1_val));
        mt2 = (m_cnt == int'(cmp2_val));
        mt3 = (m_cnt == int'(cmp3_val));
        mt4 = (m_cnt == int'(cmp4_val));
        kind = 0; op = 1'b0; cl = 1'b0; ph = 1'b1;
        if (!updown_mode) begin
            case (filt_code)
                4'b0010: begin kind = 1; op = roll; cl = mt2; end
                4'b0100: begin kind = 1; op = roll; cl = mt4; end
                4'b1101: begin kind = 2; op = roll; cl = mt2; end
                4'b1110: begin kind = 2; op = roll; cl = mt3; end
                4'b1111: kind = 3;
                default: kind = 0;
            endcase
        end else begin
            case (filt_code)
                4'b0010: begin kind = 1; op = mt1 && m_up; cl = mt2 && m_up; ph = m_up; end
                4'b0100: begin kind = 1; op = mt3 && m_up; cl = mt4 && m_up; ph = m_up; end
                4'b1101: begin kind = 2; op = mt2 && m_up; cl = mt3 && m_up; ph = m_up; end
                4'b1110: begin kind = 2; op = mt2 && !m_up; cl = mt3 && !m_up; ph = !m_up; end
                4'b1111: begin kind = 2; op = mt2 && m_up; cl = mt3 && !m_up; end
                default: kind = 0;
            endcase
        end
        e_act = (kind == 1 || kind == 2) && ph && !cl && (op || m_held);
        case (kind)
            1:       e_out = raw_evt && !e_act;
            2:       e_out = raw_evt && e_act;
            3:       e_out = raw_evt && ext_window;
            default: e_out = raw_evt;
        endcase
    endtask

    task automatic step(input logic r, input logic x, input string tag);
        logic e_out, e_act, edit;
        int per;
        raw_evt    = r;
        ext_window = x;
        #1;
        model_eval(e_out, e_act);
        vectors++;
        if (evt_out !== e_out) begin
            fails++;
            $display("FAIL %s: evt_out=%0b expected %0b (mode=%0b code=%b roll=%0d cnt=%0d up=%0b)",
                     tag, evt_out, e_out, updown_mode, filt_code, roll_mode, m_cnt, m_up);
        end
        edit = !run && (filt_code != m_pcode || updown_mode != m_pmode);
        m_held = edit ? 1'b0 : e_act;
        m_pcode = filt_code;
        m_pmode = updown_mode;
        per = int'(period);
        if (run) begin
            if (!updown_mode) begin
                m_up = 1'b1;
                m_cnt = (m_cnt >= per) ? 0 : m_cnt + 1;
            end else if (m_up) begin
                if (m_cnt >= per) begin m_up = 1'b0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_up = 1'b1; m_cnt = (per == 0) ? 0 : 1; end
                else m_cnt = m_cnt - 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cmp(input int set);
        case (set)
            0: begin period = 9; cmp1_val = 2; cmp2_val = 4; cmp3_val = 6; cmp4_val = 7; end
            1: begin period = 9; cmp1_val = 0; cmp2_val = 9; cmp3_val = 3; cmp4_val = 0; end
            default: begin period = 7; cmp1_val = 1; cmp2_val = 0; cmp3_val = 3; cmp4_val = 7; end
        endcase
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [3:0] codes [7];
        int cyc;
        codes = '{4'b0010, 4'b0100, 4'b1101, 4'b1110, 4'b1111, 4'b0000, 4'b1011};
        rst = 1'b1; run = 1'b0; updown_mode = 1'b0; filt_code = 4'b0010; roll_mode = 2'd1;
        raw_evt = 1'b0; ext_window = 1'b0;
        period = 9; cmp1_val = 1; cmp2_val = 3; cmp3_val = 5; cmp4_val = 7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_up = 1'b1; m_held = 1'b0; m_pcode = filt_code; m_pmode = updown_mode;

        // R3: count starts at zero, so the bottom roll-over blanks the first event
        step(1'b1, 1'b0, "R3");
        run = 1'b1;
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R3 R4 R5");

        // Near-exhaustive sweep of mode, code, roll-over placement and compare sets
        cyc = 0;
        for (int cs = 0; cs < 3; cs++) begin
            for (int md = 0; md < 2; md++) begin
                for (int ci = 0; ci < 7; ci++) begin
                    for (int ro = 0; ro < 4; ro++) begin
                        run = 1'b0;
                        load_cmp(cs);
                        updown_mode = md[0];
                        filt_code   = codes[ci];
                        roll_mode   = ro[1:0];
                        step(1'b1, 1'b0, req_tag(updown_mode, filt_code));
                        run = 1'b1;
                        for (int k = 0; k < 42; k++) begin
                            cyc++;
                            step((cyc % 5) != 3, ((cyc / 3) % 2) == 1, req_tag(updown_mode, filt_code));
                        end
                    end
                end
            end
        end

        // R12: open the spanning window, stop, hold, edit the code, restore it
        run = 1'b0;
        load_cmp(0);
        updown_mode = 1'b1;
        filt_code = 4'b1111;
        roll_mode = 2'd0;
        step(1'b1, 1'b0, "R12 R9");
        run = 1'b1;
        for (int k = 0; k < 60 && !(m_held && m_cnt != int'(cmp2_val)); k++)
            step(1'b1, 1'b0, "R12 R9");
        run = 1'b0;
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, "R12 held while stopped");
        filt_code = 4'b0000;
        step(1'b1, 1'b0, "R12 R10");
        filt_code = 4'b1111;
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, "R12 cleared after edit");
        run = 1'b1;
        for (int k = 0; k < 30; k++) step(1'b1, 1'b0, "R12 R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule